// File: doc/BRIEF.md
# Dual-Output Priority Interrupt Selector

This block arbitrates among up to three banks of 32 interrupt lines and reports a winner on each of two independent outputs: a normal request channel and a fast request channel. Each line arrives with four already-captured attributes, supplied as plain vectors: a pending bit, a mask bit, a steering bit that picks the channel, and a programmable priority. The block searches all lines in a single combinational pass for every channel. It registers the outcome on the next clock edge.

Each channel holds an armed flag. While the flag is set, the first clock edge that finds a candidate with the global permit asserted raises the channel's request, latches the winning line code and clears the flag. From then on, the code and the request stay frozen, whatever the lines do, until software pulses that channel's re-arm input. The re-arm drops the request, sets the flag again, and re-runs the check on the same edge.

Top module: `dual_prio_intsel`

## Requirements
- R1: A line is a candidate for a channel only when its pending bit is 1 and its mask bit is 0 (1 means masked). Its steering bit must also select that channel: 1 selects the fast channel and 0 selects the normal channel.
- R2: Among candidates, the smaller priority value wins, and 0 is the most urgent.
- R3: When candidates share the winning priority, the one with the highest global line number wins.
- R4: The reported code is the global line number 32·bank + bit, where bank b bit k is vector position 32·b + k. The code always lies below the line count.
- R5: On a clock edge where a channel is armed (or being re-armed), has at least one candidate and the global permit is 1, the block does three things after that edge. It sets the channel's request to 1, sets its armed flag to 0 and latches the winner's code.
- R6: While the global permit input is 0, no request rises. A pending raise takes effect on the first edge after the permit returns to 1, with no re-arm needed.
- R7: While a channel is not armed and not being re-armed, its request stays 1 and its code stays unchanged, whatever the line inputs do.
- R8: Re-arm bit 0 acts on the normal channel and bit 1 on the fast channel. When the edge has no candidate or no permit, a re-arm clears the request and sets the armed flag. When the edge has a candidate and the permit, the new winner is latched and the request stays 1.
- R9: After reset both armed flags are 1, both requests are 0 and both codes are 0.
- R10: The two channels are independent. A re-arm or a candidate on one channel leaves the other channel's request, code and armed flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pend_i | input | 32·NUM_BANKS | Pending bit per line |
| mask_i | input | 32·NUM_BANKS | Mask bit per line, 1 blocks the line |
| steer_i | input | 32·NUM_BANKS | Channel steering per line, 1 = fast |
| prio_i | input | 32·NUM_BANKS·PRIO_W | Priority per line, line n in bits [n·PRIO_W +: PRIO_W] |
| permit_i | input | 1 | Global permit, 0 blocks all raises |
| rearm_i | input | 2 | Re-arm pulse, bit 0 normal, bit 1 fast |
| irq_req_o | output | 1 | Normal channel request |
| fiq_req_o | output | 1 | Fast channel request |
| irq_code_o | output | CODE_W | Latched normal winner code |
| fiq_code_o | output | CODE_W | Latched fast winner code |
| irq_armed_o | output | 1 | Normal channel armed flag |
| fiq_armed_o | output | 1 | Fast channel armed flag |

## Verification
Every result is due one clock edge after its stimulus. The search is combinational, and only the request, the code and the armed flag are registered, so inputs and re-arm pulses applied before an edge show up on the outputs right after that edge. The bench drives on the falling edge, lets exactly one rising edge pass, and then samples on the following falling edge. For the frozen-state and permit checks, it holds the new stimulus over several edges and samples after each one. This confirms that nothing changes late.

// File: rtl/dpis_pkg.sv
package dpis_pkg;
   localparam int unsigned BANK_LINES = 32;
   localparam int unsigned MAX_BANKS  = 3;

   typedef enum logic {
      CH_NORMAL = 1'b0,
      CH_FAST   = 1'b1
   } chan_e;
endpackage

// File: rtl/dpis_cand.sv
// Per-channel candidate filter: pending, unmasked and steered to this channel.
module dpis_cand
   import dpis_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 3,
   parameter chan_e       CHANNEL   = CH_NORMAL,
   localparam int unsigned LINES    = NUM_BANKS * BANK_LINES
) (
   input  logic [LINES-1:0] pend_i,
   input  logic [LINES-1:0] mask_i,
   input  logic [LINES-1:0] steer_i,
   output logic [LINES-1:0] cand_o
);
   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic [BANK_LINES-1:0] sel_w;
      if (CHANNEL == CH_FAST) begin : g_fast
         assign sel_w = steer_i[b*BANK_LINES +: BANK_LINES];
      end else begin : g_norm
         assign sel_w = ~steer_i[b*BANK_LINES +: BANK_LINES];
      end
      assign cand_o[b*BANK_LINES +: BANK_LINES] =
         pend_i[b*BANK_LINES +: BANK_LINES] &
         ~mask_i[b*BANK_LINES +: BANK_LINES] & sel_w;
   end
endmodule

// File: rtl/dpis_search.sv
// Combinational priority search; later lines win ties by using <=.
module dpis_search #(
   parameter int unsigned LINES  = 96,
   parameter int unsigned PRIO_W = 5,
   localparam int unsigned CODE_W = (LINES > 1) ? $clog2(LINES) : 1
) (
   input  logic [LINES-1:0]        cand_i,
   input  logic [LINES*PRIO_W-1:0] prio_i,
   output logic [CODE_W-1:0]       win_o,
   output logic                    any_o
);
   logic [PRIO_W-1:0] best_p;

   always_comb begin
      best_p = '1;
      win_o  = '0;
      for (int i = 0; i < LINES; i++) begin
         if (cand_i[i] && (prio_i[i*PRIO_W +: PRIO_W] <= best_p)) begin
            best_p = prio_i[i*PRIO_W +: PRIO_W];
            win_o  = CODE_W'(i);
         end
      end
   end

   assign any_o = |cand_i;

   always_comb begin
      if (!any_o) begin
         a_none_zero_r4: assert (win_o == '0)
            else $error("search code nonzero with no candidate");
      end
   end
endmodule

// File: rtl/dpis_chan.sv
// Per-channel request, armed flag and latched winner code.
module dpis_chan #(
   parameter int unsigned CODE_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              any_i,
   input  logic              permit_i,
   input  logic              rearm_i,
   input  logic [CODE_W-1:0] win_i,
   output logic              req_o,
   output logic              armed_o,
   output logic [CODE_W-1:0] code_o
);
   logic              req_q, arm_q;
   logic [CODE_W-1:0] code_q;
   logic              arm_eff, fire;

   assign arm_eff = arm_q | rearm_i;
   assign fire    = arm_eff & any_i & permit_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q  <= 1'b0;
         arm_q  <= 1'b1;
         code_q <= '0;
      end else if (fire) begin
         req_q  <= 1'b1;
         arm_q  <= 1'b0;
         code_q <= win_i;
      end else begin
         req_q  <= req_q & ~rearm_i;
         arm_q  <= arm_eff;
      end
   end

   assign req_o   = req_q;
   assign armed_o = arm_q;
   assign code_o  = code_q;

   p_arm_req_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      arm_q != req_q);

   p_raise_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_q || rearm_i) && any_i && permit_i
      |=> req_q && !arm_q && code_q == $past(win_i));

   p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !permit_i |=> !$rose(req_q));

   p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !arm_q && !rearm_i |=> req_q && $stable(code_q));

   p_rearm_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rearm_i && !(any_i && permit_i) |=> arm_q && !req_q && $stable(code_q));
endmodule

// File: rtl/dual_prio_intsel.sv
module dual_prio_intsel
   import dpis_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 3,
   parameter int unsigned PRIO_W    = 6,
   localparam int unsigned LINES    = NUM_BANKS * BANK_LINES,
   localparam int unsigned CODE_W   = $clog2(LINES)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [LINES-1:0]        pend_i,
   input  logic [LINES-1:0]        mask_i,
   input  logic [LINES-1:0]        steer_i,
   input  logic [LINES*PRIO_W-1:0] prio_i,
   input  logic                    permit_i,
   input  logic [1:0]              rearm_i,
   output logic                    irq_req_o,
   output logic                    fiq_req_o,
   output logic [CODE_W-1:0]       irq_code_o,
   output logic [CODE_W-1:0]       fiq_code_o,
   output logic                    irq_armed_o,
   output logic                    fiq_armed_o
);
   if (NUM_BANKS < 1 || NUM_BANKS > MAX_BANKS) begin : g_bad_banks
      $error("NUM_BANKS must be 1 to 3");
   end
   if (PRIO_W != 5 && PRIO_W != 6) begin : g_bad_prio
      $error("PRIO_W must be 5 or 6");
   end

   logic              req_w  [2];
   logic              arm_w  [2];
   logic [CODE_W-1:0] code_w [2];

   for (genvar c = 0; c < 2; c++) begin : g_ch
      localparam chan_e CH = (c == 1) ? CH_FAST : CH_NORMAL;
      logic [LINES-1:0]  cand_w;
      logic [CODE_W-1:0] win_w;
      logic              any_w;

      dpis_cand #(.NUM_BANKS(NUM_BANKS), .CHANNEL(CH)) u_cand (
         .pend_i (pend_i),
         .mask_i (mask_i),
         .steer_i(steer_i),
         .cand_o (cand_w)
      );

      dpis_search #(.LINES(LINES), .PRIO_W(PRIO_W)) u_search (
         .cand_i(cand_w),
         .prio_i(prio_i),
         .win_o (win_w),
         .any_o (any_w)
      );

      dpis_chan #(.CODE_W(CODE_W)) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .any_i   (any_w),
         .permit_i(permit_i),
         .rearm_i (rearm_i[c]),
         .win_i   (win_w),
         .req_o   (req_w[c]),
         .armed_o (arm_w[c]),
         .code_o  (code_w[c])
      );
   end

   assign irq_req_o   = req_w[0];
   assign fiq_req_o   = req_w[1];
   assign irq_code_o  = code_w[0];
   assign fiq_code_o  = code_w[1];
   assign irq_armed_o = arm_w[0];
   assign fiq_armed_o = arm_w[1];

   p_code_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(irq_code_o) < LINES) && (int'(fiq_code_o) < LINES));

   p_indep_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !rearm_i[1] && !fiq_armed_o |=> $stable(fiq_code_o) && fiq_req_o);
endmodule

// File: tb/dual_prio_intsel_tb.sv
module dual_prio_intsel_tb;
   localparam int NB = 2;
   localparam int PW = 5;
   localparam int L  = NB * 32;
   localparam int CW = $clog2(L);

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [L-1:0]    pend = '0, mask = '0, steer = '0;
   logic [PW-1:0]   pr [L];
   logic [L*PW-1:0] prio_flat;
   logic            permit = 1'b1;
   logic [1:0]      rearm = 2'b00;
   logic            irq_req, fiq_req, irq_arm, fiq_arm;
   logic [CW-1:0]   irq_code, fiq_code;

   int n_tests = 0;
   int n_fail  = 0;

   always #2.5 clk = ~clk;

   always_comb
      for (int i = 0; i < L; i++) prio_flat[i*PW +: PW] = pr[i];

   dual_prio_intsel #(.NUM_BANKS(NB), .PRIO_W(PW)) u_dut (
      .clk(clk), .rst_n(rst_n), .pend_i(pend), .mask_i(mask),
      .steer_i(steer), .prio_i(prio_flat), .permit_i(permit),
      .rearm_i(rearm), .irq_req_o(irq_req), .fiq_req_o(fiq_req),
      .irq_code_o(irq_code), .fiq_code_o(fiq_code),
      .irq_armed_o(irq_arm), .fiq_armed_o(fiq_arm)
   );

   task automatic chk(string tag, int act, int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // apply re-arm pulse, let one rising edge pass, sample at next falling edge
   task automatic pulse(logic [1:0] which);
      rearm = which;
      @(negedge clk);
      rearm = 2'b00;
   endtask

   task automatic clear_lines();
      pend = '0; mask = '0; steer = '0;
      for (int i = 0; i < L; i++) pr[i] = '0;
   endtask

   initial begin
      #(5.0 * 150000);
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      clear_lines();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      chk("R9 irq_req", irq_req, 0);
      chk("R9 fiq_req", fiq_req, 0);
      chk("R9 irq_code", irq_code, 0);
      chk("R9 fiq_code", fiq_code, 0);
      chk("R9 irq_arm", irq_arm, 1);
      chk("R9 fiq_arm", fiq_arm, 1);

      // R1 / R4: single line per channel, masked and cross-steered distractors
      for (int i = 0; i < L; i++) begin
         for (int ch = 0; ch < 2; ch++) begin
            int j, k;
            j = (i + 5) % L;
            k = (i + 9) % L;
            clear_lines();
            pend[i] = 1'b1; steer[i] = ch[0];
            pend[j] = 1'b1; steer[j] = ~ch[0];
            pend[k] = 1'b1; steer[k] = ch[0]; mask[k] = 1'b1;
            pulse(2'b11);
            if (ch == 1) begin
               chk("R1 fiq_req", fiq_req, 1);
               chk("R4 fiq_code", fiq_code, i);
               chk("R1 irq_code cross", irq_code, j);
            end else begin
               chk("R1 irq_req", irq_req, 1);
               chk("R4 irq_code", irq_code, i);
               chk("R1 fiq_code cross", fiq_code, j);
            end
         end
      end

      // R2: full-field priority sweeps on the normal channel
      for (int r = 0; r < 8; r++) begin
         int best, idx;
         clear_lines();
         pend = '1;
         best = 99; idx = 0;
         for (int i = 0; i < L; i++) begin
            pr[i] = PW'((i * (2 * r + 3) + r * 5 + 1) % 32);
            if (int'(pr[i]) <= best) begin best = int'(pr[i]); idx = i; end
         end
         pulse(2'b01);
         chk("R2 irq_code", irq_code, idx);
         chk("R2 irq_req", irq_req, 1);
      end

      // R3: equal priorities, sparse pending sets, fast channel
      for (int r = 0; r < 16; r++) begin
         int idx;
         clear_lines();
         steer = '1;
         idx = 0;
         for (int i = 0; i < L; i++) begin
            pr[i] = PW'(9);
            pend[i] = ((i * (r + 3) + r) % 7) < 2;
            if (pend[i]) idx = i;
         end
         pend[0] = 1'b1;
         pulse(2'b10);
         chk("R3 fiq_code", fiq_code, idx);
      end

      // R7: frozen after raise
      clear_lines();
      pend[20] = 1'b1;
      pulse(2'b01);
      chk("R7 setup code", irq_code, 20);
      pend = '0; pend[40] = 1'b1; pr[40] = '0; pr[20] = 5'd31;
      for (int c = 0; c < 4; c++) begin
         @(negedge clk);
         chk("R7 code held", irq_code, 20);
         chk("R7 req held", irq_req, 1);
         chk("R7 armed low", irq_arm, 0);
      end
      pend = '0;
      @(negedge clk);
      chk("R7 req held no cand", irq_req, 1);

      // R8: re-arm with no candidate drops request
      pulse(2'b01);
      chk("R8 irq_req dropped", irq_req, 0);
      chk("R8 irq_arm set", irq_arm, 1);
      chk("R8 code kept", irq_code, 20);
      // R5: armed, candidate appears, raises without re-arm
      pend[33] = 1'b1;
      @(negedge clk);
      chk("R5 irq_req raise", irq_req, 1);
      chk("R5 irq_code", irq_code, 33);
      chk("R5 irq_arm cleared", irq_arm, 0);
      // R8: re-arm with candidate present keeps request, latches new winner
      pend[50] = 1'b1;
      pulse(2'b01);
      chk("R8 immediate req", irq_req, 1);
      chk("R8 immediate code", irq_code, 50);

      // R6: permit low blocks raising
      clear_lines();
      pend[7] = 1'b1;
      permit = 1'b0;
      pulse(2'b01);
      for (int c = 0; c < 3; c++) begin
         chk("R6 blocked req", irq_req, 0);
         chk("R6 blocked arm", irq_arm, 1);
         @(negedge clk);
      end
      permit = 1'b1;
      @(negedge clk);
      chk("R6 released req", irq_req, 1);
      chk("R6 released code", irq_code, 7);

      // R10: channels independent
      clear_lines();
      pend[3] = 1'b1;
      pend[60] = 1'b1; steer[60] = 1'b1;
      pulse(2'b11);
      chk("R10 setup irq", irq_code, 3);
      chk("R10 setup fiq", fiq_code, 60);
      pend[60] = 1'b0;
      pulse(2'b10);
      chk("R10 fiq dropped", fiq_req, 0);
      chk("R10 irq req kept", irq_req, 1);
      chk("R10 irq code kept", irq_code, 3);
      chk("R10 irq arm kept", irq_arm, 0);
      pend[61] = 1'b1; steer[61] = 1'b1;
      @(negedge clk);
      chk("R10 fiq raise", fiq_code, 61);
      chk("R10 irq unaffected", irq_code, 3);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule